// File: doc/BRIEF.md
# Port-Write Key Sequence Unlocker

This block watches every write the CPU makes to its I/O space. It compares the bytes sent to one selected port page against a fixed 17-byte key. The key must arrive in exact order, one byte per write. Once the final key byte has been accepted, an unlock flag rises. That flag gates access to extended registers elsewhere in the chip, and those registers stay unreachable until it is set.

The port page is picked by the high byte of the I/O address, which is BC hex. The low address byte plays no part in the decode. Writes to other pages and cycles with no write leave the match position alone. A wrong byte drops the position back to the start, unless that byte is itself the first key byte. In that case the position restarts at one.

After the flag sets it stays set until reset. Every later port write is ignored. A progress index is also brought out for debug: it is the number of key bytes matched so far.

Top module: `unlock_seq_detect`

## Requirements
- R1: While reset is held, and in the cycle after it is released, `unlocked` is 0 and `progress` is 0. A reset applied after unlocking also clears both.
- R2: A write with `io_wr`=1, `io_addr[15:8]`=8'hBC and `io_data` equal to the key byte at index `progress` raises `progress` by one. The new value is visible after the clock edge that samples the write.
- R3: The low address byte `io_addr[7:0]` has no effect on port selection. A key byte written at BCFF advances `progress` in the same way as one written at BC00.
- R4: A write whose high address byte is not 8'hBC leaves `progress` unchanged. So does a cycle with `io_wr`=0.
- R5: A port write whose data differs from the expected key byte sets `progress` to 1 if the data is 8'hFF. Any other data sets it to 0. This applies at every position, including the last one.
- R6: When the 17th key byte matches, `unlocked` becomes 1 and `progress` becomes 17 after the same clock edge.
- R7: Once `unlocked` is 1, it stays 1 and `progress` stays 17 until reset, whatever is written to any port.
- R8: The key in index order 0..16 is FF, 00, FF, 77, B3, 51, A8, D4, 62, 39, 9C, 46, 2B, 15, 8A, CD, EE (hex).
- R9: `unlocked` stays 0 while fewer than 17 consecutive key bytes have matched. This includes the point where 16 have matched and the 17th is wrong.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | I/O write strobe, one write per high cycle |
| io_addr | input | 16 | I/O address of the write |
| io_data | input | 8 | Data byte of the write |
| unlocked | output | 1 | Sticky flag, set once the full key has been written |
| progress | output | 5 | Number of key bytes matched so far (17 when unlocked) |

## Verification
Both outputs come straight from one register stage. The effect of a write presented during a cycle therefore appears right after the next rising edge, and it is stable until the following edge. The bench drives each write on a falling edge and removes the strobe on the next falling edge. It samples `progress` and `unlocked` at that second falling edge, exactly one rising edge after the write was captured. Idle cycles and writes to other ports are checked the same way, after at least one full sampling edge has passed.

// File: rtl/unlock_key_pkg.sv
package unlock_key_pkg;

    localparam int KEY_BYTES = 17;
    localparam int POS_W     = $clog2(KEY_BYTES + 1);
    localparam int BYTE_W    = 8;

    typedef logic [POS_W-1:0]  pos_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        pos_t pos;
        logic open;
    } tracker_state_t;

    function automatic byte_t key_at(input int idx);
        byte_t b;
        case (idx)
            0:  b = 8'hFF;
            1:  b = 8'h00;
            2:  b = 8'hFF;
            3:  b = 8'h77;
            4:  b = 8'hB3;
            5:  b = 8'h51;
            6:  b = 8'hA8;
            7:  b = 8'hD4;
            8:  b = 8'h62;
            9:  b = 8'h39;
            10: b = 8'h9C;
            11: b = 8'h46;
            12: b = 8'h2B;
            13: b = 8'h15;
            14: b = 8'h8A;
            15: b = 8'hCD;
            16: b = 8'hEE;
            default: b = 8'h00;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/io_port_decode.sv
module io_port_decode #(
    parameter int              ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 16'hBC00,
    parameter logic [ADDR_W-1:0] PORT_MASK = 16'hFF00
) (
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    // Only the bits set in PORT_MASK take part in the compare.
    logic [ADDR_W-1:0] masked;

    always_comb begin
        masked = addr & PORT_MASK;
        hit    = wr && (masked == (PORT_ADDR & PORT_MASK));
    end
endmodule

// File: rtl/key_seq_tracker.sv
module key_seq_tracker
    import unlock_key_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  port_wr,
    input  byte_t wr_byte,
    output pos_t  pos,
    output logic  open
);
    localparam int SLOTS = 1 << POS_W;

    tracker_state_t st_d, st_q;
    logic [SLOTS-1:0] slot_match;
    logic             byte_ok;
    logic             restart_hit;

    // One comparator per key slot; slots past the key never match.
    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        if (i < KEY_BYTES) begin : g_key
            assign slot_match[i] = (wr_byte == key_at(i));
        end else begin : g_pad
            assign slot_match[i] = 1'b0;
        end
    end

    always_comb begin
        byte_ok     = slot_match[st_q.pos];
        restart_hit = (wr_byte == key_at(0));
        st_d        = st_q;
        if (port_wr && !st_q.open) begin
            if (byte_ok) begin
                st_d.pos = st_q.pos + pos_t'(1);
                if (int'(st_q.pos) == KEY_BYTES - 1) begin
                    st_d.open = 1'b1;
                end
            end else if (restart_hit) begin
                st_d.pos = pos_t'(1);
            end else begin
                st_d.pos = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pos  = st_q.pos;
    assign open = st_q.open;

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !port_wr |=> $stable(st_q.pos)) else $error("position moved without port write"); // R4

    AST_STICKY_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.open |=> (st_q.open && int'(st_q.pos) == KEY_BYTES)) else $error("unlock not sticky"); // R7

    AST_OPEN_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.open) |-> (int'(st_q.pos) == KEY_BYTES && int'($past(st_q.pos)) == KEY_BYTES - 1))
        else $error("unlock without final key byte"); // R6

    AST_LOCKED_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.open |-> int'(st_q.pos) < KEY_BYTES) else $error("position past key while locked"); // R9

    AST_STEP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (port_wr && !st_q.open) |=> (int'(st_q.pos) <= int'($past(st_q.pos)) + 1))
        else $error("position jumped"); // R2
endmodule

// File: rtl/unlock_seq_detect.sv
module unlock_seq_detect
    import unlock_key_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 16'hBC00,
    parameter logic [ADDR_W-1:0] PORT_MASK = 16'hFF00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [7:0]        io_data,
    output logic              unlocked,
    output logic [POS_W-1:0]  progress
);
    logic port_wr;

    io_port_decode #(
        .ADDR_W   (ADDR_W),
        .PORT_ADDR(PORT_ADDR),
        .PORT_MASK(PORT_MASK)
    ) u_decode (
        .wr  (io_wr),
        .addr(io_addr),
        .hit (port_wr)
    );

    key_seq_tracker u_track (
        .clk    (clk),
        .rst_n  (rst_n),
        .port_wr(port_wr),
        .wr_byte(io_data),
        .pos    (progress),
        .open   (unlocked)
    );

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (!unlocked && progress == '0)) else $error("reset did not clear"); // R1
endmodule

// File: tb/tb_unlock_seq_detect.sv
module tb_unlock_seq_detect;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_wr = 1'b0;
    logic [15:0] io_addr = 16'h0000;
    logic [7:0]  io_data = 8'h00;
    logic        unlocked;
    logic [4:0]  progress;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    localparam logic [7:0] KEY [17] = '{8'hFF, 8'h00, 8'hFF, 8'h77, 8'hB3, 8'h51,
        8'hA8, 8'hD4, 8'h62, 8'h39, 8'h9C, 8'h46, 8'h2B, 8'h15, 8'h8A, 8'hCD, 8'hEE};

    unlock_seq_detect dut (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
        .io_data(io_data), .unlocked(unlocked), .progress(progress)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Drive one write for one cycle; outputs are sampled one edge later.
    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_wr = 1'b1; io_addr = a; io_data = d;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1", "unlocked after reset", int'(unlocked), 0);
        chk("R1", "progress after reset", int'(progress), 0);
    endtask

    task automatic t_partial();
        for (int i = 0; i < 5; i++) begin
            wr(16'hBC00, KEY[i]);
            chk("R2", "progress step", int'(progress), i + 1);
            chk("R8", "key byte accepted", int'(progress), i + 1);
        end
        chk("R9", "locked mid key", int'(unlocked), 0);
    endtask

    task automatic t_other_port();
        wr(16'h7F00, KEY[5]);
        chk("R4", "other page write", int'(progress), 5);
        wr(16'hBD00, 8'h12);
        chk("R4", "neighbour page write", int'(progress), 5);
        @(negedge clk); @(negedge clk);
        chk("R4", "idle cycles", int'(progress), 5);
    endtask

    task automatic t_low_byte();
        wr(16'hBCFF, KEY[5]);
        chk("R3", "low byte FF", int'(progress), 6);
        wr(16'hBC5A, KEY[6]);
        chk("R3", "low byte 5A", int'(progress), 7);
    endtask

    task automatic t_mismatch();
        wr(16'hBC00, 8'h12);
        chk("R5", "wrong byte clears", int'(progress), 0);
        wr(16'hBC00, 8'hFF);
        chk("R5", "first key byte", int'(progress), 1);
        wr(16'hBC00, 8'hFF);
        chk("R5", "FF at index 1 restarts", int'(progress), 1);
        wr(16'hBC00, 8'h00);
        chk("R5", "continue after restart", int'(progress), 2);
        wr(16'hBC00, 8'h00);
        chk("R5", "wrong 00 at index 2", int'(progress), 0);
    endtask

    task automatic t_fail_last();
        wr(16'hBC00, 8'h33);
        for (int i = 0; i < 16; i++) wr(16'hBC00, KEY[i]);
        chk("R2", "sixteen matched", int'(progress), 16);
        chk("R9", "locked at sixteen", int'(unlocked), 0);
        wr(16'hBC00, 8'hED);
        chk("R5", "wrong last byte", int'(progress), 0);
        chk("R9", "wrong last stays locked", int'(unlocked), 0);
    endtask

    task automatic t_full();
        for (int i = 0; i < 17; i++) begin
            wr(16'hBC00, KEY[i]);
            if (i < 16) chk("R9", "locked before end", int'(unlocked), 0);
        end
        chk("R6", "unlocked after key", int'(unlocked), 1);
        chk("R6", "progress at end", int'(progress), 17);
    endtask

    task automatic t_sticky();
        wr(16'hBC00, 8'h00);
        wr(16'hBC00, 8'hFF);
        wr(16'h7F00, 8'h55);
        wr(16'hBC00, KEY[0]);
        chk("R7", "flag sticky", int'(unlocked), 1);
        chk("R7", "progress held", int'(progress), 17);
        do_reset();
        chk("R1", "reset clears flag", int'(unlocked), 0);
        chk("R1", "reset clears progress", int'(progress), 0);
    endtask

    initial begin
        t_reset();
        t_partial();
        t_other_port();
        t_low_byte();
        t_mismatch();
        t_fail_last();
        t_full();
        t_sticky();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule